// File: doc/BRIEF.md
# Dualoct Beat Codec

This block sits between a narrow double-data-rate memory pin interface and the wide word used inside the memory core. Each external transfer, or beat, is 18 bits wide and carries two bytes. Every byte travels with its own ninth bit, which is an odd-parity bit. The pins move data on both clock edges. The block therefore sees two beats per core clock: the beat of the first edge and the beat of the second edge. Eight beats, which take four clocks, make one 128-bit dualoct. A dualoct is the smallest unit the core addresses, so the block supports no partial transfer.

On the write path the block collects the beats of a burst into a dualoct. It also keeps the received ninth bit of every byte and flags any byte whose parity is wrong. On the read path it takes a dualoct through a valid/ready handshake and sends it back out as four clocks of beat pairs, with odd parity generated for each byte. The read side can take the next dualoct during the last clock of the current burst, so bursts can follow one another with no idle clock between them.

Top module: `dualoct_codec`

## Requirements
- R1: While reset is held and in the first clock after it, `dualoct_valid` and `rd_beat_valid` are 0 and `rd_ready` is 1.
- R2: Byte n of a dualoct occupies bits [8n+7:8n]. In write clock k of a burst, the first-edge beat (`wr_beats[17:0]`) carries bytes 4k and 4k+1, and the second-edge beat (`wr_beats[35:18]`) carries bytes 4k+2 and 4k+3. Within a beat, bits [7:0] hold the lower byte and bit 8 holds its parity. Bits [16:9] hold the upper byte and bit 17 holds its parity.
- R3: `dualoct_valid` is high for exactly one clock, in the clock after the edge that samples the fourth beat pair of a burst. At that time bit n of `dualoct_par` equals the parity bit received with byte n.
- R4: Parity is odd: the nine bits of a correct byte contain an odd number of ones. `dualoct_par_err` is high together with `dualoct_valid` if and only if some byte of that burst failed the check. The flag is cleared when each new burst starts.
- R5: A clock with `wr_valid` low does not advance a write burst. The burst resumes with the next clock that has `wr_valid` high.
- R6: A clock with `wr_valid` high but no `wr_start`, while no burst is open, is ignored. No dualoct results from it.
- R7: A clock with `wr_valid` and `wr_start` both high always begins a new burst at clock 0. Any partly collected dualoct and its error state are dropped.
- R8: `rd_ready` is high when the read side is idle and during the last clock of a burst, and low during the other three clocks of a burst. A dualoct is accepted at a clock edge where `rd_valid` and `rd_ready` are both high. Its first beat pair appears in the next clock, with `rd_first` high.
- R9: The read beats use the same lane layout as R2, with beat pair k coming from bytes 4k to 4k+3 of the accepted word. Every ninth bit is the odd parity of its byte.
- R10: A dualoct accepted during the last clock of a burst begins in the very next clock, so `rd_beat_valid` stays high across the two bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one beat pair per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Marks clock 0 of a write burst (used only with wr_valid) |
| wr_valid | input | 1 | wr_beats holds a beat pair this clock |
| wr_beats | input | 36 | Write beat pair; first-edge beat in the low 18 bits |
| dualoct_valid | output | 1 | One-clock strobe: a full write dualoct is available |
| dualoct_data | output | 128 | Assembled dualoct, byte n in bits [8n+7:8n] |
| dualoct_par | output | 16 | Received parity bit of each byte |
| dualoct_par_err | output | 1 | Some byte of the burst had even parity |
| rd_valid | input | 1 | rd_data holds a dualoct to send |
| rd_ready | output | 1 | Read side can accept a dualoct this clock |
| rd_data | input | 128 | Dualoct to serialize |
| rd_beat_valid | output | 1 | rd_beats holds a beat pair this clock |
| rd_first | output | 1 | This beat pair is clock 0 of a read burst |
| rd_beats | output | 36 | Read beat pair with generated parity |

## Verification
The bench targets the lane mapping with varied patterns. A wrong byte or beat ordering would show up as swapped bytes in the compared dualoct or beats. It puts idle clocks inside a write burst and sends beats with no burst open. A counter that advanced on every clock would give a dualoct that is shifted, or one that should not exist. It corrupts single parity bits, including one in a burst that is then dropped by a restart. A sticky flag that was never cleared would then show as a false error on the next clean dualoct. On the read side it sends back-to-back words. Releasing ready too early would cut a burst short, and releasing it too late would leave an idle clock between the bursts.

// File: rtl/dualoct_pkg.sv
package dualoct_pkg;

    // Width of a counter that indexes n positions (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dualoct_lane_check.sv
// Splits a group of 9-bit lanes into data bytes, received parity bits and
// per-lane odd-parity failures.
module dualoct_lane_check #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic [LANES*(LANE_W+1)-1:0] beats,
    output logic [LANES*LANE_W-1:0]     data,
    output logic [LANES-1:0]            par,
    output logic [LANES-1:0]            bad
);
    localparam int FIELD_W = LANE_W + 1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [FIELD_W-1:0] field;
        assign field                      = beats[l*FIELD_W +: FIELD_W];
        assign data[l*LANE_W +: LANE_W]   = field[LANE_W-1:0];
        assign par[l]                     = field[LANE_W];
        assign bad[l]                     = ~(^field);
    end
endmodule

// File: rtl/dualoct_lane_gen.sv
// Builds 9-bit lanes (byte plus odd-parity bit) from a group of bytes.
module dualoct_lane_gen #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic [LANES*LANE_W-1:0]     data,
    output logic [LANES*(LANE_W+1)-1:0] beats
);
    localparam int FIELD_W = LANE_W + 1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] byte_v;
        assign byte_v                         = data[l*LANE_W +: LANE_W];
        assign beats[l*FIELD_W +: FIELD_W]    = {~(^byte_v), byte_v};
    end
endmodule

// File: rtl/dualoct_wr_pack.sv
// Write path: collects beat pairs of a burst into one dualoct.
module dualoct_wr_pack #(
    parameter int LANE_W         = 8,
    parameter int LANES_PER_BEAT = 2,
    parameter int BEATS_PER_CLK  = 2,
    parameter int CLKS_PER_BURST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic valid,
    input  logic [BEATS_PER_CLK*LANES_PER_BEAT*(LANE_W+1)-1:0] beats,
    output logic out_valid,
    output logic [LANE_W*LANES_PER_BEAT*BEATS_PER_CLK*CLKS_PER_BURST-1:0] out_data,
    output logic [LANES_PER_BEAT*BEATS_PER_CLK*CLKS_PER_BURST-1:0]        out_par,
    output logic out_err
);
    localparam int LANES_CLK = LANES_PER_BEAT * BEATS_PER_CLK;
    localparam int SLICE_W   = LANE_W * LANES_CLK;
    localparam int WORD_W    = SLICE_W * CLKS_PER_BURST;
    localparam int PAR_W     = LANES_CLK * CLKS_PER_BURST;
    localparam int CNT_W     = dualoct_pkg::idx_width(CLKS_PER_BURST);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BURST - 1);

    typedef struct packed {
        logic              open;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] acc;
        logic [PAR_W-1:0]  par;
        logic              err;
        logic              done;
    } wr_state_t;

    wr_state_t st_d, st_q;

    logic [SLICE_W-1:0]   dec_data;
    logic [LANES_CLK-1:0] dec_par;
    logic [LANES_CLK-1:0] dec_bad;
    logic                 capture;
    logic [CNT_W-1:0]     idx;

    dualoct_lane_check #(
        .LANE_W (LANE_W),
        .LANES  (LANES_CLK)
    ) u_check (
        .beats (beats),
        .data  (dec_data),
        .par   (dec_par),
        .bad   (dec_bad)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        capture   = 1'b0;
        idx       = st_q.cnt;
        if (valid && start) begin
            capture  = 1'b1;
            idx      = '0;
            st_d.err = 1'b0;
        end else if (valid && st_q.open) begin
            capture = 1'b1;
        end
        if (capture) begin
            st_d.acc[int'(idx)*SLICE_W +: SLICE_W]   = dec_data;
            st_d.par[int'(idx)*LANES_CLK +: LANES_CLK] = dec_par;
            st_d.err = st_d.err | (|dec_bad);
            if (idx == LAST) begin
                st_d.open = 1'b0;
                st_d.cnt  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.open = 1'b1;
                st_d.cnt  = idx + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.done;
    assign out_data  = st_q.acc;
    assign out_par   = st_q.par;
    assign out_err   = st_q.err;
endmodule

// File: rtl/dualoct_rd_serial.sv
// Read path: accepts a dualoct and emits it as beat pairs with parity.
module dualoct_rd_serial #(
    parameter int LANE_W         = 8,
    parameter int LANES_PER_BEAT = 2,
    parameter int BEATS_PER_CLK  = 2,
    parameter int CLKS_PER_BURST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  logic [LANE_W*LANES_PER_BEAT*BEATS_PER_CLK*CLKS_PER_BURST-1:0] in_data,
    output logic beat_valid,
    output logic first,
    output logic [BEATS_PER_CLK*LANES_PER_BEAT*(LANE_W+1)-1:0] beats
);
    localparam int LANES_CLK = LANES_PER_BEAT * BEATS_PER_CLK;
    localparam int SLICE_W   = LANE_W * LANES_CLK;
    localparam int WORD_W    = SLICE_W * CLKS_PER_BURST;
    localparam int CLK_W     = LANES_CLK * (LANE_W + 1);
    localparam int CNT_W     = dualoct_pkg::idx_width(CLKS_PER_BURST);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BURST - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
    } rd_state_t;

    rd_state_t st_d, st_q;

    logic [SLICE_W-1:0] slice;
    logic [CLK_W-1:0]   enc;

    assign in_ready = !st_q.active || (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (in_valid && in_ready) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.word   = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slice = st_q.word[int'(st_q.cnt)*SLICE_W +: SLICE_W];

    dualoct_lane_gen #(
        .LANE_W (LANE_W),
        .LANES  (LANES_CLK)
    ) u_gen (
        .data  (slice),
        .beats (enc)
    );

    assign beat_valid = st_q.active;
    assign first      = st_q.active && (st_q.cnt == '0);
    assign beats      = st_q.active ? enc : '0;
endmodule

// File: rtl/dualoct_codec.sv
module dualoct_codec #(
    parameter int LANE_W         = 8,
    parameter int LANES_PER_BEAT = 2,
    parameter int BEATS_PER_CLK  = 2,
    parameter int CLKS_PER_BURST = 4,
    localparam int CLK_W  = BEATS_PER_CLK * LANES_PER_BEAT * (LANE_W + 1),
    localparam int WORD_W = LANE_W * LANES_PER_BEAT * BEATS_PER_CLK * CLKS_PER_BURST,
    localparam int PAR_W  = LANES_PER_BEAT * BEATS_PER_CLK * CLKS_PER_BURST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_valid,
    input  logic [CLK_W-1:0]  wr_beats,
    output logic              dualoct_valid,
    output logic [WORD_W-1:0] dualoct_data,
    output logic [PAR_W-1:0]  dualoct_par,
    output logic              dualoct_par_err,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rd_beat_valid,
    output logic              rd_first,
    output logic [CLK_W-1:0]  rd_beats
);
    dualoct_wr_pack #(
        .LANE_W         (LANE_W),
        .LANES_PER_BEAT (LANES_PER_BEAT),
        .BEATS_PER_CLK  (BEATS_PER_CLK),
        .CLKS_PER_BURST (CLKS_PER_BURST)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (wr_start),
        .valid     (wr_valid),
        .beats     (wr_beats),
        .out_valid (dualoct_valid),
        .out_data  (dualoct_data),
        .out_par   (dualoct_par),
        .out_err   (dualoct_par_err)
    );

    dualoct_rd_serial #(
        .LANE_W         (LANE_W),
        .LANES_PER_BEAT (LANES_PER_BEAT),
        .BEATS_PER_CLK  (BEATS_PER_CLK),
        .CLKS_PER_BURST (CLKS_PER_BURST)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (rd_valid),
        .in_ready   (rd_ready),
        .in_data    (rd_data),
        .beat_valid (rd_beat_valid),
        .first      (rd_first),
        .beats      (rd_beats)
    );
endmodule

// File: rtl/dualoct_codec_chk.sv
module dualoct_codec_chk #(
    parameter int LANE_W         = 8,
    parameter int LANES_PER_BEAT = 2,
    parameter int BEATS_PER_CLK  = 2,
    parameter int CLKS_PER_BURST = 4
) (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic dualoct_valid,
    input logic rd_valid,
    input logic rd_ready,
    input logic rd_beat_valid,
    input logic rd_first,
    input logic [BEATS_PER_CLK*LANES_PER_BEAT*(LANE_W+1)-1:0] rd_beats
);
    localparam int LANES_CLK = LANES_PER_BEAT * BEATS_PER_CLK;
    localparam int FIELD_W   = LANE_W + 1;

    logic [7:0] seen_q;
    logic [7:0] idx;
    logic       par_ok;

    assign idx = rd_first ? 8'd0 : seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (rd_beat_valid) begin
            seen_q <= idx + 8'd1;
        end
    end

    always_comb begin
        par_ok = 1'b1;
        for (int l = 0; l < LANES_CLK; l++) begin
            if (!(^rd_beats[l*FIELD_W +: FIELD_W])) par_ok = 1'b0;
        end
    end

    p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dualoct_valid |=> !dualoct_valid);

    p_wr_follows_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dualoct_valid |-> $past(wr_valid));

    p_rd_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> rd_first);

    p_ready_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_beat_valid && (idx < 8'(CLKS_PER_BURST - 1))) |-> !rd_ready);

    p_rd_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_beat_valid |-> par_ok);

    p_rd_nogap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_beat_valid && rd_ready && rd_valid) |=> rd_beat_valid);
endmodule

bind dualoct_codec dualoct_codec_chk #(
    .LANE_W         (LANE_W),
    .LANES_PER_BEAT (LANES_PER_BEAT),
    .BEATS_PER_CLK  (BEATS_PER_CLK),
    .CLKS_PER_BURST (CLKS_PER_BURST)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .dualoct_valid (dualoct_valid),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_beat_valid (rd_beat_valid),
    .rd_first      (rd_first),
    .rd_beats      (rd_beats)
);

// File: tb/test_dualoct_codec.sv
module test_dualoct_codec;
    localparam int CLK_PERIOD = 10;
    localparam int CLKS       = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_start, wr_valid;
    logic [35:0]  wr_beats;
    logic         dualoct_valid, dualoct_par_err;
    logic [127:0] dualoct_data;
    logic [15:0]  dualoct_par;
    logic         rd_valid, rd_ready, rd_beat_valid, rd_first;
    logic [127:0] rd_data;
    logic [35:0]  rd_beats;

    dualoct_codec i_dualoct_codec (
        .clk (clk), .rst_n (rst_n),
        .wr_start (wr_start), .wr_valid (wr_valid), .wr_beats (wr_beats),
        .dualoct_valid (dualoct_valid), .dualoct_data (dualoct_data),
        .dualoct_par (dualoct_par), .dualoct_par_err (dualoct_par_err),
        .rd_valid (rd_valid), .rd_ready (rd_ready), .rd_data (rd_data),
        .rd_beat_valid (rd_beat_valid), .rd_first (rd_first), .rd_beats (rd_beats)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [127:0] data;
        logic [15:0]  par;
        logic         err;
    } wexp_t;

    wexp_t        wq[$];
    logic [127:0] rq[$];
    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Beat pair of clock k with the R2 lane layout; flip inverts chosen parity bits.
    function automatic logic [35:0] enc_clock(input logic [127:0] w, input int k,
                                              input logic [15:0] flip);
        logic [35:0] r;
        r = '0;
        for (int b = 0; b < 2; b++) begin
            for (int l = 0; l < 2; l++) begin
                int n;
                logic [7:0] by;
                n  = 4*k + 2*b + l;
                by = w[8*n +: 8];
                r[b*18 + l*9 +: 9] = {(~(^by)) ^ flip[n], by};
            end
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_par(input logic [127:0] w, input logic [15:0] flip);
        logic [15:0] p;
        for (int n = 0; n < 16; n++) p[n] = (~(^w[8*n +: 8])) ^ flip[n];
        return p;
    endfunction

    function automatic logic [127:0] rnd_word();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic wr_clock(input logic st, input logic [35:0] bt);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_start = st;
        wr_beats = bt;
    endtask

    task automatic wr_idle();
        @(negedge clk);
        wr_valid = 1'b0;
        wr_start = 1'b0;
        wr_beats = {$urandom, 4'h5};
    endtask

    task automatic wr_burst(input logic [127:0] w, input logic [15:0] flip, input bit gaps);
        wexp_t e;
        e.data = w;
        e.par  = exp_par(w, flip);
        e.err  = |flip;
        wq.push_back(e);
        for (int k = 0; k < CLKS; k++) begin
            if (gaps && k > 0) begin
                wr_idle();
                wr_idle();
            end
            wr_clock(k == 0, enc_clock(w, k, flip));
        end
        wr_idle();
        check(dualoct_valid == 1'b1, "R3", "valid after fourth clock", 128'(dualoct_valid), 128'd1);
        @(negedge clk);
        check(dualoct_valid == 1'b0, "R3", "valid lasts one clock", 128'(dualoct_valid), 128'd0);
    endtask

    task automatic rd_send(input logic [127:0] w);
        bit acc;
        rd_valid = 1'b1;
        rd_data  = w;
        do begin
            acc = rd_ready;
            if (acc) rq.push_back(w);
            @(negedge clk);
        end while (!acc);
    endtask

    // Write monitor (scoreboard).
    always @(negedge clk) begin
        if (rst_n && dualoct_valid) begin
            if (wq.size() == 0) begin
                check(1'b0, "R6", "unexpected dualoct", dualoct_data, 128'd0);
            end else begin
                wexp_t e;
                e = wq.pop_front();
                check(dualoct_data == e.data, "R2", "dualoct data", dualoct_data, e.data);
                check(dualoct_par == e.par, "R3", "parity vector", 128'(dualoct_par), 128'(e.par));
                check(dualoct_par_err == e.err, "R4", "parity error flag",
                      128'(dualoct_par_err), 128'(e.err));
            end
        end
    end

    // Read monitor (scoreboard).
    int           rk      = 0;
    int           run     = 0;
    int           run_max = 0;
    logic [127:0] cur     = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_beat_valid) begin
                run++;
                if (run > run_max) run_max = run;
                if (rd_first) begin
                    rk = 0;
                    if (rq.size() == 0) begin
                        check(1'b0, "R8", "read burst without accept", 128'd1, 128'd0);
                    end else begin
                        cur = rq.pop_front();
                    end
                end
                if (rk >= CLKS) begin
                    check(1'b0, "R8", "read burst too long", 128'(rk), 128'(CLKS - 1));
                end else begin
                    check(rd_beats == enc_clock(cur, rk, 16'h0), "R9", "read beat pair",
                          128'(rd_beats), 128'(enc_clock(cur, rk, 16'h0)));
                    check(rd_ready == (rk == CLKS - 1), "R8", "ready during burst",
                          128'(rd_ready), 128'(rk == CLKS - 1));
                end
                rk++;
            end else begin
                run = 0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] wa, wb;
        rst_n    = 1'b0;
        wr_start = 1'b0;
        wr_valid = 1'b0;
        wr_beats = '0;
        rd_valid = 1'b0;
        rd_data  = '0;
        repeat (3) @(negedge clk);
        check(dualoct_valid == 1'b0 && rd_beat_valid == 1'b0 && rd_ready == 1'b1, "R1",
              "outputs in reset", {dualoct_valid, rd_beat_valid, rd_ready}, 128'b001);
        rst_n = 1'b1;
        @(negedge clk);
        check(dualoct_valid == 1'b0 && rd_beat_valid == 1'b0 && rd_ready == 1'b1, "R1",
              "outputs after reset", {dualoct_valid, rd_beat_valid, rd_ready}, 128'b001);

        // R2: several patterns.
        wa = '0;
        for (int n = 0; n < 16; n++) wa[8*n +: 8] = 8'(n + 1);
        wr_burst(wa, 16'h0, 1'b0);
        wr_burst({128{1'b1}}, 16'h0, 1'b0);
        wr_burst('0, 16'h0, 1'b0);
        wr_burst(rnd_word(), 16'h0, 1'b0);

        // R5: idle clocks inside a burst.
        wr_burst(rnd_word(), 16'h0, 1'b1);

        // R4: single bad parity bits, then a clean burst clears the flag.
        wr_burst(rnd_word(), 16'h0020, 1'b0);
        wr_burst(rnd_word(), 16'h8000, 1'b1);
        wr_burst(rnd_word(), 16'h0, 1'b0);

        // R6: beats with no burst open are ignored.
        for (int k = 0; k < CLKS; k++) wr_clock(1'b0, enc_clock(rnd_word(), k, 16'h0));
        wr_idle();
        check(dualoct_valid == 1'b0, "R6", "no dualoct from unopened beats", 128'(dualoct_valid), 128'd0);
        @(negedge clk);
        check(dualoct_valid == 1'b0, "R6", "still no dualoct", 128'(dualoct_valid), 128'd0);
        wr_burst(rnd_word(), 16'h0, 1'b0);

        // R7: restart mid-burst drops the partial word and its parity error.
        wb = rnd_word();
        wr_clock(1'b1, enc_clock(wb, 0, 16'h0001));
        wr_clock(1'b0, enc_clock(wb, 1, 16'h0));
        wr_burst(rnd_word(), 16'h0, 1'b0);
        wb = rnd_word();
        wr_clock(1'b1, enc_clock(wb, 0, 16'h0));
        wr_clock(1'b0, enc_clock(wb, 1, 16'h0));
        wr_clock(1'b0, enc_clock(wb, 2, 16'h0));
        wr_burst(rnd_word(), 16'h0, 1'b1);

        // R8/R9: single read bursts with gaps between them.
        @(negedge clk);
        rd_send(wa);
        rd_valid = 1'b0;
        repeat (6) @(negedge clk);
        rd_send(rnd_word());
        rd_valid = 1'b0;
        repeat (6) @(negedge clk);

        // R10: back-to-back read bursts.
        run_max = 0;
        rd_send(rnd_word());
        rd_send(rnd_word());
        rd_send({128{1'b1}});
        rd_valid = 1'b0;
        repeat (8) @(negedge clk);
        check(run_max == 3*CLKS, "R10", "continuous read beats", 128'(run_max), 128'(3*CLKS));

        check(wq.size() == 0, "R3", "all write dualocts delivered", 128'(wq.size()), 128'd0);
        check(rq.size() == 0, "R8", "all read words sent", 128'(rq.size()), 128'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule